// File: doc/BRIEF.md
# Serial Configuration Register Port

This block is a write-only, three-wire serial port that loads a bank of configuration registers. A host holds the active-low select low and shifts in a 16-bit word, one bit per rising edge of the serial clock and least significant bit first. The first four bits carry the register address and the remaining twelve carry the data. When select returns high, the word is written to the addressed register, but only if exactly sixteen serial clocks were seen. Any other frame is dropped without effect.

The three serial pins are brought into the system clock domain through a two-stage synchroniser, and all edge detection happens in that domain. The serial clock must therefore stay well below the system clock; at most 5 MHz is assumed. The whole bank is presented as one flat parallel output. The control register at address 2 holds two special bits. Bit 11 is an active-low software reset: writing it as 0 restores every register to its default value. Bit 10 starts calibration: writing it as 1 produces a one-cycle start pulse, and the bit stays set until the calibration-done input clears it.

Top module: `cfg_serial_regs`

## Requirements
- R1: After `rst_n` is released, register 2 reads 0x809 (bit 11 = 1, bit 10 = 0, bits 4:0 = 9), every other register reads 0 and `cal_start` is low.
- R2: While `cs_n` is low, `sdata` is captured on each rising edge of `sck`. The first bit captured is word bit 0. Word bits 3:0 give the register address and word bits 15:4 give the 12-bit data, with word bit 4 as data bit 0. Register n appears on `regs_o[12n+11:12n]`.
- R3: A register keeps its old value during a frame, including after all sixteen bits have arrived, until `cs_n` rises.
- R4: A frame with fewer than 16 `sck` rising edges before `cs_n` rises changes no register.
- R5: A frame with more than 16 `sck` rising edges before `cs_n` rises changes no register.
- R6: A complete frame addressed to address 15 changes no register.
- R7: A complete frame to address 2 with data bit 11 = 0 returns every register, including register 2, to its R1 value. No calibration pulse is produced, even if data bit 10 is 1.
- R8: A complete frame to address 2 with data bit 11 = 1 and data bit 10 = 1 drives `cal_start` high for exactly one `clk` cycle, and register 2 reads back with bit 10 set.
- R9: `cal_done` high for one `clk` cycle clears bit 10 of register 2 at that clock edge and leaves every other bit unchanged.
- R10: `sck` edges while `cs_n` is high are ignored. Each frame starts its bit count at zero when `cs_n` falls.
- R11: A committed write appears on `regs_o`, together with its `cal_start` pulse, at the third rising edge of `clk` after `cs_n` goes high at the input. It does not appear earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock from the host, asynchronous |
| cs_n | input | 1 | Active-low frame select, asynchronous |
| sdata | input | 1 | Serial data, least significant bit first |
| cal_done | input | 1 | Calibration complete; clears the calibration bit |
| regs_o | output | 180 | All 15 registers, 12 bits each, register 0 in the low bits |
| cal_start | output | 1 | One-cycle calibration start pulse |

## Verification
On every cycle, the assertions check four things: the bank holds still unless a frame is committed or calibration completes; writes to address 15 leave the bank alone; a software reset lands on the default image; and every calibration pulse lasts one cycle and follows a matching write. Only the bench scenarios can show how the serial stream is assembled: bit order, the rejection of short and long frames, `sck` activity with select high being ignored, and the exact three-cycle commit latency. Those depend on the shape of the pin waveforms rather than on a one-cycle relation.

// File: rtl/cfg_ser_pkg.sv
package cfg_ser_pkg;
  localparam int unsigned CTRL_ADDR = 2;
  localparam int unsigned CAL_BIT   = 10;
  localparam int unsigned SWRST_BIT = 11;
  localparam int unsigned CLAMP_DEF = 9;

  // Reset image of one register, wide enough for any data width in use.
  function automatic logic [31:0] reg_default(input int unsigned idx);
    logic [31:0] v;
    v = '0;
    if (idx == CTRL_ADDR) begin
      v[SWRST_BIT] = 1'b1;
      v[4:0]       = 5'(CLAMP_DEF);
    end
    return v;
  endfunction
endpackage

// File: rtl/cfg_ser_sync.sv
module cfg_ser_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(STAGES); i++) st[i] <= RST_VAL;
    end else begin
      st[0] <= d_i;
      for (int i = 1; i < int'(STAGES); i++) st[i] <= st[i-1];
    end
  end

  assign q_o = st[STAGES-1];
endmodule

// File: rtl/cfg_ser_frame.sv
module cfg_ser_frame #(
  parameter int unsigned FRAME_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sck_s,
  input  logic               cs_n_s,
  input  logic               sdata_s,
  output logic               wr_stb,
  output logic [FRAME_W-1:0] wr_word
);
  localparam int unsigned CNT_W = $clog2(FRAME_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(FRAME_W + 1);

  logic               sck_q, cs_q;
  logic [CNT_W-1:0]   cnt;
  logic [FRAME_W-1:0] sh;
  logic               sck_rise, cs_rise;

  assign sck_rise = sck_s & ~sck_q;
  assign cs_rise  = cs_n_s & ~cs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b0;
      cs_q  <= 1'b1;
      cnt   <= '0;
      sh    <= '0;
    end else begin
      sck_q <= sck_s;
      cs_q  <= cs_n_s;
      if (cs_n_s) begin
        cnt <= '0;
      end else if (sck_rise) begin
        sh <= {sdata_s, sh[FRAME_W-1:1]};
        if (cnt != CNT_OVER) cnt <= cnt + 1'b1;
      end
    end
  end

  // Only a frame of exactly FRAME_W clocks is handed to the bank.
  assign wr_stb  = cs_rise && (cnt == CNT_FULL);
  assign wr_word = sh;
endmodule

// File: rtl/cfg_ser_bank.sv
module cfg_ser_bank
  import cfg_ser_pkg::*;
#(
  parameter int unsigned NREG   = 15,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_stb,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic                     cal_done,
  output logic [NREG*DATA_W-1:0]   regs_o,
  output logic                     cal_start_o
);
  logic ctrl_hit, swrst, cal_req;

  assign ctrl_hit = wr_stb && (wr_addr == ADDR_W'(CTRL_ADDR));
  assign swrst    = ctrl_hit && !wr_data[SWRST_BIT];
  assign cal_req  = ctrl_hit && wr_data[SWRST_BIT] && wr_data[CAL_BIT];

  for (genvar gi = 0; gi < int'(NREG); gi++) begin : g_reg
    localparam logic [31:0] DEF = reg_default(gi);
    logic [DATA_W-1:0] r;
    logic              hit;
    assign hit = wr_stb && (wr_addr == ADDR_W'(gi));

    if (gi == int'(CTRL_ADDR)) begin : g_ctrl
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              r <= DEF[DATA_W-1:0];
        else if (swrst)          r <= DEF[DATA_W-1:0];
        else if (hit)            r <= wr_data;
        else if (cal_done)       r[CAL_BIT] <= 1'b0;
      end
    end else begin : g_plain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              r <= DEF[DATA_W-1:0];
        else if (swrst)          r <= DEF[DATA_W-1:0];
        else if (hit)            r <= wr_data;
      end
    end

    assign regs_o[gi*DATA_W +: DATA_W] = r;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cal_start_o <= 1'b0;
    else        cal_start_o <= cal_req;
  end
endmodule

// File: rtl/cfg_serial_regs.sv
module cfg_serial_regs #(
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned DATA_W      = 12,
  parameter int unsigned NREG        = 15,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   sck,
  input  logic                   cs_n,
  input  logic                   sdata,
  input  logic                   cal_done,
  output logic [NREG*DATA_W-1:0] regs_o,
  output logic                   cal_start
);
  localparam int unsigned FRAME_W = ADDR_W + DATA_W;

  logic [2:0]         pins_s;
  logic               wr_stb;
  logic [FRAME_W-1:0] wr_word;

  cfg_ser_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({cs_n, sck, sdata}),
    .q_o   (pins_s)
  );

  cfg_ser_frame #(.FRAME_W(FRAME_W)) u_frame (
    .clk     (clk),
    .rst_n   (rst_n),
    .sck_s   (pins_s[1]),
    .cs_n_s  (pins_s[2]),
    .sdata_s (pins_s[0]),
    .wr_stb  (wr_stb),
    .wr_word (wr_word)
  );

  cfg_ser_bank #(.NREG(NREG), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bank (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_stb      (wr_stb),
    .wr_addr     (wr_word[ADDR_W-1:0]),
    .wr_data     (wr_word[FRAME_W-1:ADDR_W]),
    .cal_done    (cal_done),
    .regs_o      (regs_o),
    .cal_start_o (cal_start)
  );
endmodule

// File: rtl/cfg_serial_regs_chk.sv
module cfg_serial_regs_chk
  import cfg_ser_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 12,
  parameter int unsigned NREG   = 15
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        wr_stb,
  input logic [ADDR_W+DATA_W-1:0]    wr_word,
  input logic                        cal_done,
  input logic [NREG*DATA_W-1:0]      regs_o,
  input logic                        cal_start
);
  localparam int unsigned CAL_POS = CTRL_ADDR * DATA_W + CAL_BIT;

  logic [ADDR_W-1:0]      wa;
  logic [DATA_W-1:0]      wd;
  logic [NREG*DATA_W-1:0] def_vec;

  assign wa = wr_word[ADDR_W-1:0];
  assign wd = wr_word[ADDR_W+DATA_W-1:ADDR_W];

  for (genvar gi = 0; gi < int'(NREG); gi++) begin : g_def
    localparam logic [31:0] D = reg_default(gi);
    assign def_vec[gi*DATA_W +: DATA_W] = D[DATA_W-1:0];
  end

  a_r3_hold_without_commit: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_stb && !cal_done) |=> $stable(regs_o));

  a_r6_unused_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && int'(wa) >= int'(NREG) && !cal_done) |=> $stable(regs_o));

  a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && int'(wa) < int'(NREG) && int'(wa) != int'(CTRL_ADDR))
    |=> regs_o[int'($past(wa))*DATA_W +: DATA_W] == $past(wd));

  a_r7_swreset_image: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && int'(wa) == int'(CTRL_ADDR) && !wd[SWRST_BIT]) |=> (regs_o == def_vec));

  a_r8_pulse_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    cal_start |=> !cal_start);

  a_r8_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
    cal_start |-> $past(wr_stb && int'(wa) == int'(CTRL_ADDR) && wd[SWRST_BIT] && wd[CAL_BIT]));

  a_r9_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_done && !wr_stb) |=> !regs_o[CAL_POS]);
endmodule

bind cfg_serial_regs cfg_serial_regs_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NREG(NREG)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_stb    (wr_stb),
  .wr_word   (wr_word),
  .cal_done  (cal_done),
  .regs_o    (regs_o),
  .cal_start (cal_start)
);

// File: tb/sim_cfg_serial_regs.sv
`timescale 1ns/1ps
module sim_cfg_serial_regs;
  localparam int NREG = 15;
  localparam int DW   = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, sdata = 1'b0, cal_done = 1'b0;
  logic [NREG*DW-1:0] regs_o;
  logic cal_start;

  int checks = 0;
  int errors = 0;
  int pulses = 0;
  bit done = 0;

  logic [DW-1:0] exp_r [NREG];
  logic exp_cal = 1'b0;

  always #2 clk = ~clk;

  cfg_serial_regs u0 (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .sdata(sdata),
    .cal_done(cal_done), .regs_o(regs_o), .cal_start(cal_start)
  );

  function automatic logic [DW-1:0] dflt(int i);
    return (i == 2) ? 12'h809 : 12'h000;
  endfunction

  task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] rd(int i);
    return regs_o[i*DW +: DW];
  endfunction

  // Per-cycle comparison of the whole bank and the pulse against the model (R2,R11).
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (cal_start) pulses++;
      for (int i = 0; i < NREG; i++) begin
        checks++;
        if (rd(i) !== exp_r[i]) begin
          errors++;
          $display("FAIL R11 cycle model reg%0d actual %h expected %h", i, rd(i), exp_r[i]);
        end
      end
      checks++;
      if (cal_start !== exp_cal) begin
        errors++;
        $display("FAIL R8 cycle model cal_start actual %b expected %b", cal_start, exp_cal);
      end
    end
  end

  task automatic sck_bit(bit b);
    sdata = b;
    repeat (4) @(negedge clk);
    sck = 1'b1;
    repeat (4) @(negedge clk);
    sck = 1'b0;
  endtask

  task automatic frame(int nbits, logic [15:0] w);
    int a;
    logic [DW-1:0] d;
    a = int'(w[3:0]);
    d = w[15:4];
    @(negedge clk);
    cs_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < nbits; i++) sck_bit((i < 16) ? w[i] : 1'b0);
    repeat (4) @(negedge clk);
    if (a < NREG) chk($sformatf("R3 reg%0d before select rises", a), rd(a), exp_r[a]);
    cs_n = 1'b1;
    repeat (3) @(posedge clk);
    if (nbits == 16) begin
      if (a == 2 && !d[11]) begin
        for (int i = 0; i < NREG; i++) exp_r[i] = dflt(i);
      end else if (a < NREG) begin
        exp_r[a] = d;
        if (a == 2 && d[10]) exp_cal = 1'b1;
      end
    end
    @(posedge clk);
    exp_cal = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int p0;
    for (int i = 0; i < NREG; i++) exp_r[i] = dflt(i);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset image
    for (int i = 0; i < NREG; i++) chk($sformatf("R1 reg%0d default", i), rd(i), dflt(i));
    chk("R1 cal_start idle", {11'd0, cal_start}, 12'd0);

    // R2 bit order and field split
    frame(16, {12'hA5C, 4'd0});
    chk("R2 reg0 data", rd(0), 12'hA5C);
    frame(16, {12'h3C1, 4'd5});
    chk("R2 reg5 data", rd(5), 12'h3C1);

    // R4 short frame dropped
    frame(10, {12'hFFF, 4'd5});
    chk("R4 reg5 after short frame", rd(5), 12'h3C1);

    // R5 long frame dropped
    frame(17, {12'h111, 4'd5});
    chk("R5 reg5 after long frame", rd(5), 12'h3C1);

    // R6 unused address
    frame(16, {12'h777, 4'd15});
    chk("R6 reg0 after addr15", rd(0), 12'hA5C);
    chk("R6 reg5 after addr15", rd(5), 12'h3C1);

    // R10 sck activity with select high, then a clean frame
    for (int k = 0; k < 5; k++) sck_bit(1'b1);
    frame(16, {12'h0F0, 4'd7});
    chk("R10 reg7 after idle clocks", rd(7), 12'h0F0);

    // R8 calibration start
    p0 = pulses;
    frame(16, {12'hC09, 4'd2});
    chk("R8 reg2 cal bit set", rd(2), 12'hC09);
    chk("R8 pulse count", 12'(pulses - p0), 12'd1);

    // R9 calibration done
    @(negedge clk);
    cal_done = 1'b1;
    @(posedge clk);
    exp_r[2][10] = 1'b0;
    @(negedge clk);
    cal_done = 1'b0;
    repeat (2) @(negedge clk);
    chk("R9 reg2 after done", rd(2), 12'h809);
    chk("R9 reg7 untouched", rd(7), 12'h0F0);

    // R7 software reset, calibration bit also set
    p0 = pulses;
    frame(16, {12'h41F, 4'd2});
    chk("R7 reg0 default", rd(0), 12'h000);
    chk("R7 reg5 default", rd(5), 12'h000);
    chk("R7 reg2 default", rd(2), 12'h809);
    chk("R7 no pulse", 12'(pulses - p0), 12'd0);

    // R11 latency exercised again on a fresh write (model compares every cycle)
    frame(16, {12'h5A5, 4'd14});
    chk("R11 reg14 written", rd(14), 12'h5A5);

    repeat (5) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule